// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is a small associative store of `WORDS` entries, each `WIDTH` bits wide, that is searched by content rather than by address. Two holding registers sit beside the array: a comparand register and a mask register, each as wide as one entry. A search compares every valid entry against the comparand in the same cycle. Only bit positions where the mask holds a 1 take part; the others are don't-care. The result is captured in a match vector with one bit per entry.

Writes carry data but no address. The block picks the lowest-numbered free entry, stores the word there and marks it valid. When every entry is valid, the array is full and a write is dropped. A clear command frees every entry flagged in the current match vector, so a search followed by a clear removes a whole class of words at once. The match vector is reduced to an any-hit flag and to the index of its lowest set bit.

Top module: `mask_cam`

## Requirements
- R1: After reset, no entry is valid: the match vector is all zero, `hit_any` is 0, `hit_idx` is 0 and `full` is 0. A search with an all-zero mask still finds nothing.
- R2: The comparand and mask registers load from `cmp_in` and `msk_in` on the clock edge where `cmp_load` or `msk_load` is 1. A search in that same cycle uses the values held before the load.
- R3: One clock edge after a search, bit i of `match_vec` is 1 exactly when entry i is valid and agrees with the comparand on every bit where the mask is 1. For example, with comparand 101111100 and mask 111000000, the stored word 100111100 misses and the stored word 101000001 hits.
- R4: Mask bits that are 0 exclude their positions from the compare. An all-zero mask makes every valid entry hit.
- R5: A write with `full` low stores `wr_data` into the lowest-index entry that is not valid, and marks that entry valid.
- R6: `full` is 1 exactly when every entry is valid. A write while full changes no entry and no valid bit.
- R7: `hit_any` is the OR of `match_vec`. `hit_idx` is the index of the lowest set bit of `match_vec`, or 0 when no bit is set.
- R8: A clear command invalidates every entry whose `match_vec` bit is 1 and sets `match_vec` to zero. Freed entries are reused by later writes, lowest index first. A clear with an empty match vector changes nothing.
- R9: Only one command runs per cycle. Write beats search, and search beats clear; a command that loses the priority is dropped.
- R10: `match_vec` changes only on a search or a clear. Idle cycles and writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| cmp_load | input | 1 | Load the comparand register from `cmp_in` |
| cmp_in | input | WIDTH | New comparand value |
| msk_load | input | 1 | Load the mask register from `msk_in` |
| msk_in | input | WIDTH | New mask value; 1 means the bit is compared |
| wr_req | input | 1 | Store `wr_data` in the lowest free entry |
| wr_data | input | WIDTH | Word to store |
| search_req | input | 1 | Compare all entries and capture the match vector |
| clear_req | input | 1 | Invalidate the entries flagged in the match vector |
| match_vec | output | WORDS | Match register, one bit per entry |
| hit_any | output | 1 | At least one match bit is set |
| hit_idx | output | clog2(WORDS) | Index of the lowest set match bit |
| full | output | 1 | All entries are valid |

## Verification
A wrong valid bit becomes visible at the first later search with an all-zero mask: the match vector then shows the exact set of occupied entries, one cycle after the command. A word stored in the wrong slot shows up as a wrong `hit_idx` on the next exact search. A mask or comparand bit taken at the wrong time changes which entries hit in that same result cycle. A clear that frees the wrong entries is exposed twice: by the next all-zero-mask search, and by the slot the next write takes.

// File: rtl/mask_cam_pkg.sv
package mask_cam_pkg;
  // One command per cycle, chosen by fixed priority.
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_SEARCH = 2'd2,
    OP_CLEAR  = 2'd3
  } cam_op_e;
endpackage

// File: rtl/mask_cam_rst_sync.sv
module mask_cam_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mask_cam_entry.sv
module mask_cam_entry #(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             drop,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] cmp,
  input  logic [WIDTH-1:0] msk,
  output logic             hit,
  output logic             valid
);
  logic             valid_q, valid_d;
  logic [WIDTH-1:0] word_q;

  always_comb begin
    valid_d = valid_q;
    if (load)      valid_d = 1'b1;
    else if (drop) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  // Data storage needs no reset: it is qualified by valid_q.
  always_ff @(posedge clk) begin
    if (load) word_q <= wr_data;
  end

  assign hit   = valid_q && (((word_q ^ cmp) & msk) == '0);
  assign valid = valid_q;
endmodule

// File: rtl/mask_cam_alloc.sv
module mask_cam_alloc #(
  parameter int WORDS = 8
) (
  input  logic [WORDS-1:0] valid_vec,
  output logic [WORDS-1:0] grant,
  output logic             full
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (!valid_vec[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  assign full = &valid_vec;
endmodule

// File: rtl/mask_cam_prio.sv
module mask_cam_prio #(
  parameter int WORDS = 8,
  localparam int IDXW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [WORDS-1:0] vec,
  output logic             any,
  output logic [IDXW-1:0]  idx
);
  always_comb begin
    idx = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDXW'(i);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/mask_cam.sv
module mask_cam
  import mask_cam_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int WIDTH = 9,
  localparam int IDXW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_load,
  input  logic [WIDTH-1:0] cmp_in,
  input  logic             msk_load,
  input  logic [WIDTH-1:0] msk_in,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             search_req,
  input  logic             clear_req,
  output logic [WORDS-1:0] match_vec,
  output logic             hit_any,
  output logic [IDXW-1:0]  hit_idx,
  output logic             full
);
  logic             rst_sync_n;
  cam_op_e          op_cur;
  logic [WIDTH-1:0] cmp_q, cmp_d, msk_q, msk_d;
  logic [WORDS-1:0] match_q, match_d;
  logic [WORDS-1:0] valid_vec, hit_vec, grant;

  mask_cam_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  // Command decode, fixed priority: write, then search, then clear (R9).
  always_comb begin
    if (wr_req)          op_cur = OP_WRITE;
    else if (search_req) op_cur = OP_SEARCH;
    else if (clear_req)  op_cur = OP_CLEAR;
    else                 op_cur = OP_IDLE;
  end

  // Comparand and mask registers (R2).
  always_comb begin
    cmp_d = cmp_load ? cmp_in : cmp_q;
    msk_d = msk_load ? msk_in : msk_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmp_q <= '0;
      msk_q <= '0;
    end else begin
      cmp_q <= cmp_d;
      msk_q <= msk_d;
    end
  end

  mask_cam_alloc #(.WORDS(WORDS)) u_alloc (
    .valid_vec(valid_vec), .grant(grant), .full(full)
  );

  for (genvar g = 0; g < WORDS; g++) begin : g_entry
    logic ld, dr;
    assign ld = (op_cur == OP_WRITE) && grant[g];
    assign dr = (op_cur == OP_CLEAR) && match_q[g];
    mask_cam_entry #(.WIDTH(WIDTH)) u_ent (
      .clk(clk), .rst_n(rst_sync_n), .load(ld), .drop(dr),
      .wr_data(wr_data), .cmp(cmp_q), .msk(msk_q),
      .hit(hit_vec[g]), .valid(valid_vec[g])
    );
  end

  // Match register: a search captures, a clear empties, else hold (R3, R8, R10).
  always_comb begin
    unique case (op_cur)
      OP_SEARCH: match_d = hit_vec;
      OP_CLEAR:  match_d = '0;
      default:   match_d = match_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) match_q <= '0;
    else             match_q <= match_d;
  end

  mask_cam_prio #(.WORDS(WORDS)) u_prio (
    .vec(match_q), .any(hit_any), .idx(hit_idx)
  );

  assign match_vec = match_q;
endmodule

// File: rtl/mask_cam_chk.sv
module mask_cam_chk
  import mask_cam_pkg::*;
#(
  parameter int WORDS = 8,
  localparam int IDXW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input cam_op_e          op,
  input logic             wr_req,
  input logic [WORDS-1:0] valid_vec,
  input logic [WORDS-1:0] hit_vec,
  input logic [WORDS-1:0] match_vec,
  input logic             hit_any,
  input logic [IDXW-1:0]  hit_idx,
  input logic             full
);
  a_r3_search_captures: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SEARCH |=> match_vec == $past(hit_vec));

  a_r5_write_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !full |=> $countones(valid_vec) == $past($countones(valid_vec)) + 1);

  a_r6_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && full |=> $stable(valid_vec));

  a_r7_any_is_or: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any == (match_vec != '0));

  a_r7_idx_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> match_vec[hit_idx] &&
      ((match_vec & ((WORDS'(1) << hit_idx) - WORDS'(1))) == '0));

  a_r8_only_valid_match: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec & ~valid_vec) == '0);

  a_r8_clear_frees: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CLEAR |=> match_vec == '0 && (valid_vec & $past(match_vec)) == '0);

  a_r10_match_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE || op == OP_WRITE) |=> $stable(match_vec));
endmodule

bind mask_cam mask_cam_chk #(.WORDS(WORDS)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .op(op_cur), .wr_req(wr_req),
  .valid_vec(valid_vec), .hit_vec(hit_vec), .match_vec(match_vec),
  .hit_any(hit_any), .hit_idx(hit_idx), .full(full)
);

// File: tb/mask_cam_tb_top.sv
`timescale 1ns/1ps
module mask_cam_tb_top;
  localparam int W = 8;
  localparam int N = 9;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic cmp_load, msk_load, wr_req, search_req, clear_req;
  logic [N-1:0] cmp_in, msk_in, wr_data;
  logic [W-1:0] match_vec;
  logic hit_any, full;
  logic [IW-1:0] hit_idx;

  always #2.5 clk = ~clk;

  mask_cam #(.WORDS(W), .WIDTH(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_load(cmp_load), .cmp_in(cmp_in),
    .msk_load(msk_load), .msk_in(msk_in), .wr_req(wr_req), .wr_data(wr_data),
    .search_req(search_req), .clear_req(clear_req), .match_vec(match_vec),
    .hit_any(hit_any), .hit_idx(hit_idx), .full(full)
  );

  typedef struct packed {
    logic [W-1:0]  mv;
    logic          any;
    logic [IW-1:0] idx;
    logic          full;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_checks = 0;
  int    n_fails  = 0;
  bit    finished = 1'b0;

  // Reference model, built from the requirements.
  logic [N-1:0] m_word[W];
  logic [W-1:0] m_valid = '0;
  logic [W-1:0] m_match = '0;
  logic [N-1:0] m_cmp = '0, m_msk = '0;

  function automatic exp_t model_out();
    exp_t e;
    e.mv = m_match;
    e.any = |m_match;
    e.idx = '0;
    for (int i = W - 1; i >= 0; i--) if (m_match[i]) e.idx = IW'(i);
    e.full = &m_valid;
    return e;
  endfunction

  task automatic push(input string tag);
    exp_q.push_back(model_out());
    tag_q.push_back(tag);
  endtask

  // Driver: apply one cycle of stimulus, step the model, push the expectation.
  task automatic apply(input bit wr, input logic [N-1:0] wd, input bit sr, input bit cl,
                       input bit al, input logic [N-1:0] a, input bit kl,
                       input logic [N-1:0] k, input string tag);
    bit taken;
    wr_req = wr; wr_data = wd; search_req = sr; clear_req = cl;
    cmp_load = al; cmp_in = a; msk_load = kl; msk_in = k;
    @(posedge clk); #1;
    wr_req = 0; search_req = 0; clear_req = 0; cmp_load = 0; msk_load = 0;
    taken = 1'b0;
    if (wr) begin
      for (int i = 0; i < W; i++)
        if (!m_valid[i] && !taken) begin
          m_valid[i] = 1'b1; m_word[i] = wd; taken = 1'b1;
        end
    end else if (sr) begin
      for (int i = 0; i < W; i++)
        m_match[i] = m_valid[i] && (((m_word[i] ^ m_cmp) & m_msk) == '0);
    end else if (cl) begin
      m_valid = m_valid & ~m_match;
      m_match = '0;
    end
    if (al) m_cmp = a;
    if (kl) m_msk = k;
    push(tag);
  endtask

  task automatic wr(input logic [N-1:0] d, input string tag);
    apply(1, d, 0, 0, 0, '0, 0, '0, tag);
  endtask
  task automatic srch(input string tag);
    apply(0, '0, 1, 0, 0, '0, 0, '0, tag);
  endtask
  task automatic clr(input string tag);
    apply(0, '0, 0, 1, 0, '0, 0, '0, tag);
  endtask
  task automatic setck(input logic [N-1:0] a, input logic [N-1:0] k, input string tag);
    apply(0, '0, 0, 0, 1, a, 1, k, tag);
  endtask
  task automatic idle(input string tag);
    apply(0, '0, 0, 0, 0, '0, 0, '0, tag);
  endtask

  // Monitor: compare each result one half-period after its edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if ({match_vec, hit_any, hit_idx, full} !== e) begin
        n_fails++;
        $display("FAIL %s: got mv=%b any=%b idx=%0d full=%b, expected mv=%b any=%b idx=%0d full=%b",
                 t, match_vec, hit_any, hit_idx, full, e.mv, e.any, e.idx, e.full);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    cmp_load = 0; msk_load = 0; wr_req = 0; search_req = 0; clear_req = 0;
    cmp_in = '0; msk_in = '0; wr_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    push("R1 reset state");
    srch("R1 empty array, all-zero mask");
    wr(9'b100111100, "R5 first write to entry 0");
    wr(9'b101000001, "R5 second write to entry 1");
    setck(9'b101111100, 9'b111000000, "R10 register load keeps match");
    srch("R3 worked example, only entry 1 hits");
    setck(9'b000000000, 9'b000000000, "R10 idle load");
    srch("R4 zero mask hits all valid");
    setck(9'b101000001, 9'b111111111, "R10 load exact");
    srch("R3 exact compare");
    // R2: load a new comparand together with a search: old value is used.
    apply(0, '0, 1, 0, 1, 9'b100111100, 0, '0, "R2 search uses held comparand");
    srch("R2 new comparand now in use");
    wr(9'b001010101, "R5 fill entry 2");
    wr(9'b101110000, "R5 fill entry 3");
    wr(9'b101000011, "R5 fill entry 4");
    wr(9'b010101010, "R5 fill entry 5");
    wr(9'b111111111, "R5 fill entry 6");
    wr(9'b000000000, "R6 last free entry, full rises");
    wr(9'b110110110, "R6 write while full dropped");
    setck(9'b110110110, 9'b111111111, "R6 load probe");
    srch("R6 dropped word absent");
    setck(9'b000000000, 9'b000000000, "R6 load zero mask");
    srch("R6 all entries still valid");
    setck(9'b101000000, 9'b111000000, "R7 load class probe");
    srch("R7 several hits, lowest index reported");
    idle("R10 idle holds match");
    clr("R8 clear frees matched entries");
    setck(9'b000000000, 9'b000000000, "R8 load zero mask");
    srch("R8 remaining valid set");
    clr("R8 clear frees everything matched");
    srch("R8 array empty after second clear");
    clr("R8 clear with empty match vector");
    wr(9'b011011011, "R8 reuse lowest freed entry");
    wr(9'b000111000, "R8 reuse next freed entry");
    srch("R8 reused entries valid");
    setck(9'b011011011, 9'b111111111, "R10 load exact");
    srch("R5 reused word found in entry 0");
    // R9: write and search together: only the write runs.
    apply(1, 9'b111000111, 1, 0, 0, '0, 0, '0, "R9 write beats search");
    // R9: search and clear together: only the search runs.
    setck(9'b000000000, 9'b000000000, "R10 load zero mask");
    apply(0, '0, 1, 1, 0, '0, 0, '0, "R9 search beats clear");
    srch("R9 nothing was cleared");
    setck(9'b111111111, 9'b111111111, "R10 load miss probe");
    srch("R7 no hit, index zero");
    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule